// File: doc/BRIEF.md
# Cache Line State Allocation Logic

This block sits beside the tag lookup of a second-level writeback cache. For each CPU-side access it takes the line's current MESI state and read-only tag bit. It also takes the attributes of the access from the CPU side: page cache-disable, page writethrough, lock, data or code, read or write, memory or IO. From the memory side it takes line cacheable, line writethrough, direct-to-modified and read-only. From these it decides what happens to the line.

The block reports whether a read linefill or a write allocation takes place and the line state that results. It also gives the new read-only tag bit and whether the write must go to memory. It reports whether the cache data is written, and whether the data already held must be used in place of bus data. Finally it drives the caching-enable and writethrough indications returned to the CPU. The tag RAM writes and the bus sequencing are handled elsewhere; this block only gives the verdict.

A small two-state machine registers the verdict: `ST_IDLE` moves to `ST_RESP` on a valid request. `ST_RESP` stays in `ST_RESP` while requests keep arriving and returns to `ST_IDLE` otherwise. The verdict outputs are valid while the machine is in `ST_RESP`.

Top module: `line_state_alloc`

## Requirements
- R1: Line states are encoded I=0, S=1, E=2, M=3. `rsp_valid` is 1 exactly in the cycle after a cycle with `req_valid` high, and back-to-back requests give back-to-back responses. After reset every output is 0.
- R2: A memory read miss is cacheable when `ln_cacheable` is 1 and `pg_nocache`, `is_locked` are 0. With no other attribute set, it fills in E with `fill`=1, `cpu_cache_en`=1 and `cpu_wthru`=0. Across all cases, `cpu_wthru` is 0 only when the resulting state is E or M.
- R3: A read miss that is not cacheable gives `fill`=0, state I and `cpu_cache_en`=0. This covers `pg_nocache` set (which wins over `ln_cacheable`=1), `ln_cacheable`=0, and a locked read.
- R4: If `pg_wthru` or `ln_wthru` is set, a fill or allocation ends in S.
- R5: `ln_to_mod` makes a cacheable read fill end in M, but only when neither writethrough input and not `ln_readonly` is set.
- R6: A fill with `ln_readonly` ends in S with `new_ro`=1. `cpu_cache_en` is then 0 for data (`is_data`=1) and 1 for code.
- R7: A memory write miss allocates (`alloc`=1) only when it is cacheable as in R2 and `pg_wthru` is 0. The allocated line ends in M, in S if `ln_wthru` is set, and in S with `new_ro`=1 if `ln_readonly` is set. `mem_write`=1 for every write miss.
- R8: A write miss without allocation gives state I, `mem_write`=1 and `line_update`=0.
- R9: A memory read hit keeps the state and the read-only bit, whatever the values of `pg_nocache`, `pg_wthru` and `is_locked`. In that case `cpu_cache_en` is 0 only for data reads of a read-only line.
- R10: `use_cache_data` is 1 only for a locked memory read that hits a line in M.
- R11: A write hit to a read-only line gives `mem_write`=1, `line_update`=0, state S and `new_ro`=1.
- R12: A locked write hit to a line that is not read-only gives `mem_write`=1 and `line_update`=1, and keeps the state.
- R13: An unlocked write hit to a line that is not read-only sets `line_update`=1. If the line is in S, it stays in S with `mem_write`=1. If it is in E or M, it ends in M with `mem_write`=0, regardless of either writethrough input.
- R14: An IO access (`is_mem`=0) never fills or allocates and keeps the state and read-only bit. It gives `mem_write`=`is_write`, `line_update`=0 and `cpu_cache_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access attributes valid this cycle |
| is_write | input | 1 | 1 = write, 0 = read |
| is_data | input | 1 | 1 = data, 0 = code |
| is_mem | input | 1 | 1 = memory, 0 = IO |
| is_locked | input | 1 | Locked (atomic) access |
| pg_nocache | input | 1 | Page cache-disable attribute |
| pg_wthru | input | 1 | Page writethrough attribute |
| ln_cacheable | input | 1 | Memory side marks the line cacheable |
| ln_wthru | input | 1 | Memory side requests writethrough |
| ln_to_mod | input | 1 | Memory side requests direct-to-M fill |
| ln_readonly | input | 1 | Memory side marks the line read-only |
| hit_state | input | 2 | Current line state from lookup (I on miss) |
| hit_ro | input | 1 | Current read-only tag bit |
| rsp_valid | output | 1 | Verdict valid |
| fill | output | 1 | Read linefill performed |
| alloc | output | 1 | Write allocation performed |
| new_state | output | 2 | Resulting line state |
| new_ro | output | 1 | Resulting read-only bit |
| mem_write | output | 1 | Write is sent to memory |
| line_update | output | 1 | Cache line data is written |
| cpu_cache_en | output | 1 | CPU may cache the returned line |
| cpu_wthru | output | 1 | CPU must hold the line shared |
| use_cache_data | output | 1 | Use cached data, ignore bus data |

## Verification
A wrong verdict shows up in the single response cycle that follows the request. Because there is no carried state apart from `ST_IDLE`/`ST_RESP`, an error cannot surface later. A stuck state machine shows as `rsp_valid` missing or staying high one cycle after `req_valid` changes. A wrong priority between the attributes shows only for particular input combinations: writethrough against direct-to-modified, read-only against lock, cache-disable against line-cacheable. For that reason, random attribute mixes are backed by directed cases at each priority boundary.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

    localparam int ST_W = 2;

    typedef enum logic [ST_W-1:0] {
        LS_I = 2'd0,
        LS_S = 2'd1,
        LS_E = 2'd2,
        LS_M = 2'd3
    } line_st_t;

    typedef enum logic [2:0] {
        AK_IO      = 3'd0,
        AK_RD_MISS = 3'd1,
        AK_RD_HIT  = 3'd2,
        AK_WR_MISS = 3'd3,
        AK_WR_HIT  = 3'd4
    } acc_kind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } fsm_t;

    typedef struct packed {
        logic     fill;
        logic     alloc;
        line_st_t new_state;
        logic     new_ro;
        logic     mem_write;
        logic     line_update;
        logic     cpu_cache_en;
        logic     cpu_wthru;
        logic     use_cache_data;
    } verdict_t;

endpackage

// File: rtl/lsa_classify.sv
module lsa_classify
    import lsa_pkg::*;
(
    input  logic      is_write,
    input  logic      is_mem,
    input  logic      is_locked,
    input  logic      pg_nocache,
    input  logic      ln_cacheable,
    input  logic      pg_wthru,
    input  logic      ln_wthru,
    input  line_st_t  hit_state,
    output acc_kind_t kind,
    output logic      may_cache,
    output logic      wthru_any
);
    logic is_hit;

    assign is_hit    = (hit_state != LS_I);
    // cache-disable overrides line-cacheable; locked and IO never cache
    assign may_cache = ln_cacheable && !pg_nocache && !is_locked && is_mem;
    assign wthru_any = pg_wthru || ln_wthru;

    always_comb begin
        if (!is_mem)
            kind = AK_IO;
        else if (is_write)
            kind = is_hit ? AK_WR_HIT : AK_WR_MISS;
        else
            kind = is_hit ? AK_RD_HIT : AK_RD_MISS;
    end
endmodule

// File: rtl/lsa_fill_pick.sv
module lsa_fill_pick
    import lsa_pkg::*;
(
    input  logic     wthru_any,
    input  logic     ln_readonly,
    input  logic     ln_to_mod,
    input  logic     merge_write,
    output line_st_t fill_state
);
    // fixed priority: writethrough, read-only, direct-to-M, write merge, default E
    always_comb begin
        if (wthru_any)
            fill_state = LS_S;
        else if (ln_readonly)
            fill_state = LS_S;
        else if (ln_to_mod)
            fill_state = LS_M;
        else if (merge_write)
            fill_state = LS_M;
        else
            fill_state = LS_E;
    end
endmodule

// File: rtl/lsa_decide.sv
module lsa_decide
    import lsa_pkg::*;
(
    input  acc_kind_t kind,
    input  logic      may_cache,
    input  logic      pg_wthru,
    input  logic      is_write,
    input  logic      is_data,
    input  logic      is_locked,
    input  logic      ln_readonly,
    input  line_st_t  hit_state,
    input  logic      hit_ro,
    input  line_st_t  fill_state,
    output verdict_t  verdict
);
    verdict_t v;

    always_comb begin
        v = '0;
        v.new_state = LS_I;
        unique case (kind)
            AK_IO: begin
                v.new_state = hit_state;
                v.new_ro    = hit_ro && (hit_state != LS_I);
                v.mem_write = is_write;
            end
            AK_RD_MISS: begin
                v.fill = may_cache;
                if (may_cache) begin
                    v.new_state    = fill_state;
                    v.new_ro       = ln_readonly;
                    v.cpu_cache_en = !(ln_readonly && is_data);
                end
            end
            AK_RD_HIT: begin
                v.new_state      = hit_state;
                v.new_ro         = hit_ro;
                v.cpu_cache_en   = !(hit_ro && is_data);
                v.use_cache_data = is_locked && (hit_state == LS_M);
            end
            AK_WR_MISS: begin
                v.mem_write = 1'b1;
                v.alloc     = may_cache && !pg_wthru;
                if (v.alloc) begin
                    v.new_state = fill_state;
                    v.new_ro    = ln_readonly;
                end
            end
            AK_WR_HIT: begin
                v.new_ro = hit_ro;
                if (hit_ro) begin
                    v.mem_write = 1'b1;
                    v.new_state = LS_S;
                end else if (is_locked) begin
                    v.mem_write   = 1'b1;
                    v.line_update = 1'b1;
                    v.new_state   = hit_state;
                end else if (hit_state == LS_S) begin
                    v.mem_write   = 1'b1;
                    v.line_update = 1'b1;
                    v.new_state   = LS_S;
                end else begin
                    v.line_update = 1'b1;
                    v.new_state   = LS_M;
                end
            end
            default: v.new_state = LS_I;
        endcase
        v.cpu_wthru = !((v.new_state == LS_E) || (v.new_state == LS_M));
    end

    assign verdict = v;
endmodule

// File: rtl/line_state_alloc.sv
module line_state_alloc
    import lsa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       is_write,
    input  logic       is_data,
    input  logic       is_mem,
    input  logic       is_locked,
    input  logic       pg_nocache,
    input  logic       pg_wthru,
    input  logic       ln_cacheable,
    input  logic       ln_wthru,
    input  logic       ln_to_mod,
    input  logic       ln_readonly,
    input  logic [1:0] hit_state,
    input  logic       hit_ro,
    output logic       rsp_valid,
    output logic       fill,
    output logic       alloc,
    output logic [1:0] new_state,
    output logic       new_ro,
    output logic       mem_write,
    output logic       line_update,
    output logic       cpu_cache_en,
    output logic       cpu_wthru,
    output logic       use_cache_data
);
    acc_kind_t kind;
    logic      may_cache;
    logic      wthru_any;
    line_st_t  cur_st;
    line_st_t  fill_state;
    verdict_t  verdict;
    verdict_t  held_q;
    fsm_t      state_q;
    fsm_t      state_d;

    assign cur_st = line_st_t'(hit_state);

    lsa_classify u_classify (
        .is_write     (is_write),
        .is_mem       (is_mem),
        .is_locked    (is_locked),
        .pg_nocache   (pg_nocache),
        .ln_cacheable (ln_cacheable),
        .pg_wthru     (pg_wthru),
        .ln_wthru     (ln_wthru),
        .hit_state    (cur_st),
        .kind         (kind),
        .may_cache    (may_cache),
        .wthru_any    (wthru_any)
    );

    lsa_fill_pick u_fill_pick (
        .wthru_any   (wthru_any),
        .ln_readonly (ln_readonly),
        .ln_to_mod   (ln_to_mod),
        .merge_write (kind == AK_WR_MISS),
        .fill_state  (fill_state)
    );

    lsa_decide u_decide (
        .kind        (kind),
        .may_cache   (may_cache),
        .pg_wthru    (pg_wthru),
        .is_write    (is_write),
        .is_data     (is_data),
        .is_locked   (is_locked),
        .ln_readonly (ln_readonly),
        .hit_state   (cur_st),
        .hit_ro      (hit_ro),
        .fill_state  (fill_state),
        .verdict     (verdict)
    );

    // next-state logic
    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = req_valid ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // output register: verdict captured on each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (req_valid)
            held_q <= verdict;
    end

    assign rsp_valid      = (state_q == ST_RESP);
    assign fill           = rsp_valid && held_q.fill;
    assign alloc          = rsp_valid && held_q.alloc;
    assign new_state      = rsp_valid ? held_q.new_state : LS_I;
    assign new_ro         = rsp_valid && held_q.new_ro;
    assign mem_write      = rsp_valid && held_q.mem_write;
    assign line_update    = rsp_valid && held_q.line_update;
    assign cpu_cache_en   = rsp_valid && held_q.cpu_cache_en;
    assign cpu_wthru      = rsp_valid && held_q.cpu_wthru;
    assign use_cache_data = rsp_valid && held_q.use_cache_data;
endmodule

// File: rtl/lsa_chk.sv
module lsa_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       is_write,
    input logic       is_mem,
    input logic       is_locked,
    input logic       pg_wthru,
    input logic       ln_wthru,
    input logic [1:0] hit_state,
    input logic       hit_ro,
    input logic       rsp_valid,
    input logic       fill,
    input logic       alloc,
    input logic [1:0] new_state,
    input logic       mem_write,
    input logic       line_update,
    input logic       use_cache_data
);
    // R1
    rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R1
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4
    wthru_fill_shared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (pg_wthru || ln_wthru)) |=> (!(fill || alloc) || new_state == 2'd1));

    // R3
    locked_miss_nocache_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_locked && hit_state == 2'd0) |=> (!fill && !alloc));

    // R9
    read_hit_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_mem && !is_write && hit_state != 2'd0) |=> (new_state == $past(hit_state)));

    // R11
    ro_write_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_mem && is_write && hit_state != 2'd0 && hit_ro)
        |=> (mem_write && !line_update && new_state == 2'd1));

    // R13
    excl_write_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_mem && is_write && !is_locked && !hit_ro && hit_state[1])
        |=> (new_state == 2'd3 && !mem_write && line_update));

    // R10
    cache_data_in_m_chk: assert property (@(posedge clk) disable iff (!rst_n)
        use_cache_data |-> (new_state == 2'd3 && !fill && !mem_write));

    // R7
    fill_alloc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(fill && alloc));
endmodule

bind line_state_alloc lsa_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .is_write       (is_write),
    .is_mem         (is_mem),
    .is_locked      (is_locked),
    .pg_wthru       (pg_wthru),
    .ln_wthru       (ln_wthru),
    .hit_state      (hit_state),
    .hit_ro         (hit_ro),
    .rsp_valid      (rsp_valid),
    .fill           (fill),
    .alloc          (alloc),
    .new_state      (new_state),
    .mem_write      (mem_write),
    .line_update    (line_update),
    .use_cache_data (use_cache_data)
);

// File: tb/line_state_alloc_bench.sv
module line_state_alloc_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       is_write = 1'b0, is_data = 1'b0, is_mem = 1'b0, is_locked = 1'b0;
    logic       pg_nocache = 1'b0, pg_wthru = 1'b0, ln_cacheable = 1'b0;
    logic       ln_wthru = 1'b0, ln_to_mod = 1'b0, ln_readonly = 1'b0;
    logic [1:0] hit_state = 2'd0;
    logic       hit_ro = 1'b0;
    logic       rsp_valid, fill, alloc, new_ro, mem_write, line_update;
    logic       cpu_cache_en, cpu_wthru, use_cache_data;
    logic [1:0] new_state;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    line_state_alloc u_line_state_alloc (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .is_write(is_write), .is_data(is_data), .is_mem(is_mem), .is_locked(is_locked),
        .pg_nocache(pg_nocache), .pg_wthru(pg_wthru), .ln_cacheable(ln_cacheable),
        .ln_wthru(ln_wthru), .ln_to_mod(ln_to_mod), .ln_readonly(ln_readonly),
        .hit_state(hit_state), .hit_ro(hit_ro),
        .rsp_valid(rsp_valid), .fill(fill), .alloc(alloc), .new_state(new_state),
        .new_ro(new_ro), .mem_write(mem_write), .line_update(line_update),
        .cpu_cache_en(cpu_cache_en), .cpu_wthru(cpu_wthru), .use_cache_data(use_cache_data)
    );

    // stimulus vector: {wr,data,mem,lock,pgnc,pgwt,lncach,lnwt,tomod,ro,hit[1:0],hitro}
    function automatic logic [10:0] model(input logic [12:0] s);
        logic wr, dat, mem, lck, pnc, pwt, lc, lwt, tm, ro, hro;
        logic [1:0] hs;
        logic cach, f, a, nro, mw, lu, ce, uc;
        logic [1:0] ns;
        {wr, dat, mem, lck, pnc, pwt, lc, lwt, tm, ro, hs, hro} = s;
        cach = lc && !pnc && !lck && mem;
        f = 0; a = 0; nro = 0; mw = 0; lu = 0; ce = 0; uc = 0; ns = 2'd0;
        if (!mem) begin                                   // R14
            ns = hs; nro = hro && (hs != 0); mw = wr;
        end else if (!wr && hs == 0) begin                // R2 R3 R4 R5 R6
            f = cach;
            if (cach) begin
                ns = (pwt || lwt || ro) ? 2'd1 : (tm ? 2'd3 : 2'd2);
                nro = ro; ce = !(ro && dat);
            end
        end else if (!wr) begin                           // R9 R10
            ns = hs; nro = hro; ce = !(hro && dat); uc = lck && hs == 2'd3;
        end else if (hs == 0) begin                       // R7 R8
            mw = 1; a = cach && !pwt;
            if (a) begin ns = (lwt || ro) ? 2'd1 : 2'd3; nro = ro; end
        end else begin                                    // R11 R12 R13
            nro = hro;
            if (hro) begin mw = 1; ns = 2'd1; end
            else if (lck) begin mw = 1; lu = 1; ns = hs; end
            else if (hs == 2'd1) begin mw = 1; lu = 1; ns = 2'd1; end
            else begin lu = 1; ns = 2'd3; end
        end
        return {f, a, ns, nro, mw, lu, ce, !(ns[1]), uc};
    endfunction

    function automatic string tag(input logic [12:0] s);
        logic wr, dat, mem, lck, pnc, pwt, lc, lwt, tm, ro, hro;
        logic [1:0] hs;
        {wr, dat, mem, lck, pnc, pwt, lc, lwt, tm, ro, hs, hro} = s;
        if (!mem) return "R14";
        if (wr) begin
            if (hs == 0) return (lc && !pnc && !lck && !pwt) ? "R7" : "R8";
            if (hro) return "R11";
            return lck ? "R12" : "R13";
        end
        if (hs != 0) return (lck && hs == 2'd3) ? "R10" : "R9";
        if (!(lc && !pnc && !lck)) return "R3";
        if (pwt || lwt) return "R4";
        if (ro) return "R6";
        return tm ? "R5" : "R2";
    endfunction

    task automatic check_bit(input string req, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic apply(input logic [12:0] s);
        logic [10:0] exp, act;
        {is_write, is_data, is_mem, is_locked, pg_nocache, pg_wthru, ln_cacheable,
         ln_wthru, ln_to_mod, ln_readonly, hit_state, hit_ro} = s;
        req_valid = 1'b1;
        @(negedge clk);
        exp = model(s);
        act = {fill, alloc, new_state, new_ro, mem_write, line_update,
               cpu_cache_en, cpu_wthru, use_cache_data};
        checks++;
        if (!rsp_valid || act !== exp) begin
            errors++;
            $display("FAIL %s stim=%b actual=%b/%b expected=%b/1", tag(s), s, act, rsp_valid, exp);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check_bit("R1", rsp_valid | fill | alloc | new_ro | mem_write | line_update
                  | cpu_cache_en | cpu_wthru | use_cache_data | (|new_state), 1'b0, "reset outputs");
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R1", rsp_valid, 1'b0, "idle rsp_valid");
        // directed corner cases (wr,data,mem,lock,pgnc,pgwt,lncach,lnwt,tomod,ro,hit,hitro)
        apply(13'b0_1_1_0_0_0_1_0_0_0_00_0); // R2 plain fill E
        apply(13'b0_1_1_0_1_0_1_0_0_0_00_0); // R3 cache-disable beats cacheable
        apply(13'b0_1_1_1_0_0_1_0_0_0_00_0); // R3 locked read miss
        apply(13'b0_1_1_0_0_1_1_0_1_0_00_0); // R4 page wt beats to-mod
        apply(13'b0_1_1_0_0_0_1_1_1_0_00_0); // R4 line wt beats to-mod
        apply(13'b0_1_1_0_0_0_1_0_1_0_00_0); // R5 fill in M
        apply(13'b0_1_1_0_0_0_1_0_1_1_00_0); // R6 ro beats to-mod, data
        apply(13'b0_0_1_0_0_0_1_0_0_1_00_0); // R6 ro code cacheable
        apply(13'b1_1_1_0_0_0_1_0_0_0_00_0); // R7 allocate to M
        apply(13'b1_1_1_0_0_0_1_1_0_0_00_0); // R7 allocate with line wt -> S
        apply(13'b1_1_1_0_0_1_1_0_0_0_00_0); // R8 page wt blocks alloc
        apply(13'b1_1_1_1_0_0_1_0_0_0_00_0); // R8 locked write miss
        apply(13'b0_1_1_1_1_1_0_0_0_0_10_0); // R9 read hit E unaffected
        apply(13'b0_1_1_0_0_0_1_0_0_0_01_1); // R9 ro data hit not cacheable
        apply(13'b0_1_1_1_0_0_1_0_0_0_11_0); // R10 locked read hit M
        apply(13'b1_1_1_1_0_0_1_0_0_0_01_1); // R11 ro beats lock
        apply(13'b1_1_1_1_0_0_1_0_0_0_10_0); // R12 locked write hit E kept
        apply(13'b1_1_1_0_0_1_1_1_0_0_10_0); // R13 E -> M despite wt
        apply(13'b1_1_1_0_0_0_1_0_0_0_01_0); // R13 S stays S, to memory
        apply(13'b1_1_0_0_0_0_1_0_0_0_11_0); // R14 IO write to M line
        req_valid = 1'b0;
        @(negedge clk);
        check_bit("R1", rsp_valid, 1'b0, "rsp drops after last req");
        // constrained random, with random idle gaps
        for (int i = 0; i < 3000; i++) begin
            logic [12:0] s;
            s = 13'($urandom());
            if (($urandom() % 8) != 0) s[10] = 1'b1; // mostly memory
            apply(s);
            if (($urandom() % 5) == 0) begin
                req_valid = 1'b0;
                @(negedge clk);
                check_bit("R1", rsp_valid, 1'b0, "idle gap");
            end
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule